// File: doc/BRIEF.md
# Boot ROM Progress Code Latch

This block is glue logic placed next to a boot ROM. Boot firmware marks its progress by writing a code into the ROM's address range. The ROM itself cannot be written, so the block catches these writes and holds the most recent code. The held value drives a 16-segment LED digit directly, so a board that stops during start-up shows how far it got. During normal development, software can also write any value it likes to the display for tracing.

A capture mode is sampled while reset is held. In decoded mode, only a write to the highest word address of the ROM range loads the latch. In any-write mode, every write into the ROM range loads it, and the read/write line alone separates the two cycle types. In both modes the block drives the ROM output enable. The ROM answers every read, including a read of the latch address, and is kept silent during writes.

Top module: `post_code_latch`

## Requirements
- R1: While reset is high and on the cycle after it, `code_o` is all zeros, `rom_oe_n` is 1 and `seg_o` equals `SEG_POL`, which is the blank pattern.
- R2: In decoded mode (`mode_i` = 0 at reset), a cycle with `rom_sel_n` = 0, `rd_wr_n` = 0 and `addr` all ones loads `wdata` into `code_o`, visible after that clock edge.
- R3: In decoded mode, a write cycle with `rom_sel_n` = 0 to any address other than all ones leaves `code_o` unchanged.
- R4: In any-write mode (`mode_i` = 1 at reset), a write cycle with `rom_sel_n` = 0 to any address loads `wdata` into `code_o`.
- R5: A read cycle (`rd_wr_n` = 1) never changes `code_o`, whatever the address or mode. When `rom_sel_n` = 0 it drives `rom_oe_n` low after that clock edge.
- R6: After any write cycle, and after any cycle with `rom_sel_n` = 1, `rom_oe_n` is 1.
- R7: A cycle with `rom_sel_n` = 1 leaves `code_o` unchanged, even when `rd_wr_n` = 0 and `addr` is all ones.
- R8: Each segment bit `seg_o[i]` equals `code_o[i]` XOR `SEG_POL[i]` for every i below `SEG_N`. An inverted bit suits an active-low segment.
- R9: `mode_i` is taken only while reset is high. A change of `mode_i` after reset has no effect on which writes are captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also samples `mode_i` |
| mode_i | input | 1 | Capture mode: 0 = decoded address only, 1 = any write |
| rom_sel_n | input | 1 | Active-low ROM range select |
| rd_wr_n | input | 1 | Cycle type: 1 = read, 0 = write |
| addr | input | ADDR_W | Word address within the ROM range |
| wdata | input | DATA_W | Write data bus |
| rom_oe_n | output | 1 | Registered active-low ROM output enable |
| code_o | output | DATA_W | Latched progress code |
| seg_o | output | SEG_N | Registered segment drive bits |

## Verification
Any fault in the hit decode or in the mode register shows up at `code_o` on the clock edge right after the wrong cycle, either as a value that should not have loaded or as a load that went missing. It then stays there until the next captured write, so a check taken once per cycle sees it at once. A segment register that drifts from the code register breaks the XOR relation on that same cycle. A fault in the enable logic appears at `rom_oe_n` one edge after the bus cycle that caused it. The sweep runs every address, cycle type and select level in both modes, which reaches every decode path within a few hundred cycles.

// File: rtl/post_pkg.sv
package post_pkg;

  typedef enum logic {
    CAP_DECODED   = 1'b0,
    CAP_ANY_WRITE = 1'b1
  } cap_mode_e;

endpackage

// File: rtl/post_bus_decode.sv
module post_bus_decode
  import post_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_i,
  input  logic              rom_sel_n,
  input  logic              rd_wr_n,
  input  logic [ADDR_W-1:0] addr,
  output cap_mode_e         mode_q,
  output logic              load,
  output logic              oe_n_q
);

  localparam logic [ADDR_W-1:0] LATCH_ADDR = {ADDR_W{1'b1}};

  logic sel;
  logic is_wr;
  logic at_latch;

  // Capture mode is taken only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) mode_q <= cap_mode_e'(mode_i);
  end

  always_comb begin
    sel      = ~rom_sel_n;
    is_wr    = ~rd_wr_n;
    at_latch = (addr == LATCH_ADDR);
    load     = 1'b0;
    if (!rst && sel && is_wr) begin
      load = (mode_q == CAP_ANY_WRITE) || at_latch;
    end
  end

  // ROM speaks only on selected read cycles.
  always_ff @(posedge clk) begin
    if (rst) oe_n_q <= 1'b1;
    else     oe_n_q <= ~(sel & rd_wr_n);
  end

endmodule

// File: rtl/post_code_reg.sv
module post_code_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] code_q
);

  always_ff @(posedge clk) begin
    if (rst)       code_q <= '0;
    else if (load) code_q <= wdata;
  end

endmodule

// File: rtl/post_seg_drive.sv
module post_seg_drive #(
  parameter int           SEG_N   = 16,
  parameter logic [SEG_N-1:0] SEG_POL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEG_N-1:0] wbits,
  output logic [SEG_N-1:0] seg_q
);

  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    if (SEG_POL[i]) begin : g_inv
      always_ff @(posedge clk) begin
        if (rst)       seg_q[i] <= 1'b1;
        else if (load) seg_q[i] <= ~wbits[i];
      end
    end else begin : g_dir
      always_ff @(posedge clk) begin
        if (rst)       seg_q[i] <= 1'b0;
        else if (load) seg_q[i] <= wbits[i];
      end
    end
  end

endmodule

// File: rtl/post_code_latch.sv
module post_code_latch
  import post_pkg::*;
#(
  parameter int               ADDR_W  = 8,
  parameter int               DATA_W  = 32,
  parameter int               SEG_N   = 16,
  parameter logic [SEG_N-1:0] SEG_POL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_i,
  input  logic              rom_sel_n,
  input  logic              rd_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rom_oe_n,
  output logic [DATA_W-1:0] code_o,
  output logic [SEG_N-1:0]  seg_o
);

  cap_mode_e mode_q;
  logic      load;

  post_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_i),
    .rom_sel_n (rom_sel_n),
    .rd_wr_n   (rd_wr_n),
    .addr      (addr),
    .mode_q    (mode_q),
    .load      (load),
    .oe_n_q    (rom_oe_n)
  );

  post_code_reg #(.DATA_W(DATA_W)) u_code (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .wdata  (wdata),
    .code_q (code_o)
  );

  post_seg_drive #(.SEG_N(SEG_N), .SEG_POL(SEG_POL)) u_seg (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .wbits (wdata[SEG_N-1:0]),
    .seg_q (seg_o)
  );

endmodule

// File: rtl/post_code_latch_chk.sv
module post_code_latch_chk
  import post_pkg::*;
#(
  parameter int               ADDR_W  = 8,
  parameter int               DATA_W  = 32,
  parameter int               SEG_N   = 16,
  parameter logic [SEG_N-1:0] SEG_POL = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              rom_sel_n,
  input logic              rd_wr_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              rom_oe_n,
  input logic [DATA_W-1:0] code_o,
  input logic [SEG_N-1:0]  seg_o,
  input cap_mode_e         mode_q
);

  logic top_addr;
  assign top_addr = &addr;

  AST_OE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (!rom_sel_n && rd_wr_n) |=> !rom_oe_n); // R5
  AST_OE_OFF: assert property (@(posedge clk) disable iff (rst)
    (rom_sel_n || !rd_wr_n) |=> rom_oe_n); // R6
  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (rd_wr_n || rom_sel_n) |=> $stable(code_o)); // R5
  AST_LOAD_HIT: assert property (@(posedge clk) disable iff (rst)
    (!rom_sel_n && !rd_wr_n && (mode_q == CAP_ANY_WRITE || top_addr))
      |=> (code_o == $past(wdata))); // R2
  AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!rom_sel_n && !rd_wr_n && mode_q == CAP_DECODED && !top_addr)
      |=> $stable(code_o)); // R3
  AST_SEG_MATCH: assert property (@(posedge clk) disable iff (rst)
    seg_o == (code_o[SEG_N-1:0] ^ SEG_POL)); // R8
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_q)); // R9

endmodule

bind post_code_latch post_code_latch_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_N(SEG_N), .SEG_POL(SEG_POL)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rom_sel_n (rom_sel_n),
  .rd_wr_n   (rd_wr_n),
  .addr      (addr),
  .wdata     (wdata),
  .rom_oe_n  (rom_oe_n),
  .code_o    (code_o),
  .seg_o     (seg_o),
  .mode_q    (mode_q)
);

// File: tb/post_code_latch_test.sv
module post_code_latch_test;

  localparam int            CLK_PERIOD = 10;
  localparam int            AW  = 4;
  localparam int            DW  = 32;
  localparam int            SN  = 16;
  localparam logic [SN-1:0] POL = 16'hA5C3;

  logic          clk = 1'b0;
  logic          rst;
  logic          mode_i;
  logic          rom_sel_n;
  logic          rd_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          rom_oe_n;
  logic [DW-1:0] code_o;
  logic [SN-1:0] seg_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_code;
  logic          exp_oe;
  logic          run_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  post_code_latch #(.ADDR_W(AW), .DATA_W(DW), .SEG_N(SN), .SEG_POL(POL)) uut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .rom_sel_n(rom_sel_n),
    .rd_wr_n(rd_wr_n), .addr(addr), .wdata(wdata),
    .rom_oe_n(rom_oe_n), .code_o(code_o), .seg_o(seg_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, code_o, exp_code);
    chk({req, "/R8"}, {{(DW-SN){1'b0}}, seg_o}, {{(DW-SN){1'b0}}, exp_code[SN-1:0] ^ POL});
    chk({req, "/oe"}, {{(DW-1){1'b0}}, rom_oe_n}, {{(DW-1){1'b0}}, exp_oe});
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst = 1'b1; mode_i = m; rom_sel_n = 1'b1; rd_wr_n = 1'b1; addr = '0; wdata = '0;
    run_mode = m;
    @(posedge clk); @(negedge clk);
    exp_code = '0; exp_oe = 1'b1;
    check_all("R1 in reset");
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check_all("R1 after reset");
  endtask

  // One bus cycle: drive at negedge, sample at the next negedge.
  task automatic bus(input logic sel_n, input logic rd, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input string req);
    rom_sel_n = sel_n; rd_wr_n = rd; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    if (!sel_n && !rd && (run_mode || a == {AW{1'b1}})) exp_code = d;
    exp_oe = !(!sel_n && rd);
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; mode_i = 1'b0; rom_sel_n = 1'b1; rd_wr_n = 1'b1; addr = '0; wdata = '0;
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      for (int a = 0; a < (1 << AW); a++) begin
        for (int rd = 0; rd < 2; rd++) begin
          for (int s = 0; s < 2; s++) begin
            logic [DW-1:0] d;
            d = 32'h9E37_79B9 * (a + 1) + 32'h0101_0101 * (rd * 2 + s) + m * 32'h5A5A_0000;
            if (s == 1)        bus(s[0], rd[0], a[AW-1:0], d, "R7 deselected");
            else if (rd == 1)  bus(1'b0, 1'b1, a[AW-1:0], d, "R5 read");
            else if (m == 1)   bus(1'b0, 1'b0, a[AW-1:0], d, "R4 any write");
            else if (a == (1 << AW) - 1) bus(1'b0, 1'b0, a[AW-1:0], d, "R2 decoded hit");
            else               bus(1'b0, 1'b0, a[AW-1:0], d, "R3 decoded miss");
          end
        end
      end
      // R5: read of the latch address itself, then a write (R6 oe high)
      bus(1'b0, 1'b1, {AW{1'b1}}, 32'hDEAD_BEEF, "R5 read at latch address");
      bus(1'b0, 1'b0, {AW{1'b1}}, 32'h0000_FFFF, "R6 write keeps oe high");
      bus(1'b0, 1'b0, {AW{1'b1}}, 32'h1234_0000, "R8 all segments off in data");
    end
    // R9: reset in decoded mode, then raise mode_i; misses must still be ignored
    do_reset(1'b0);
    bus(1'b0, 1'b0, {AW{1'b1}}, 32'hCAFE_0042, "R9 decoded hit");
    @(negedge clk); mode_i = 1'b1;
    bus(1'b0, 1'b0, 4'h3, 32'h0BAD_0BAD, "R9 mode change ignored");
    bus(1'b0, 1'b0, 4'h0, 32'h7777_7777, "R9 mode change ignored");
    // R9 reverse: reset in any-write mode, drop mode_i afterwards
    do_reset(1'b1);
    @(negedge clk); mode_i = 1'b0;
    bus(1'b0, 1'b0, 4'h5, 32'h0055_AA11, "R9 any-write kept");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule